// File: doc/BRIEF.md
# Octave-Segmented Coefficient Lookup

This block turns a 15-bit unsigned sample into one 26-bit coefficient drawn from a 2048-word table. Small inputs have their own table entries. Larger inputs are grouped by octave, and each octave is sampled more coarsely than the one below it. The block finds the octave of the input, takes the eight bits just below its leading one, and adds a base offset for that octave. The result is an 11-bit table address. The table word at that address is registered out.

Samples enter on a valid/ready stream and coefficients leave on another, in the same order. With the output always ready, one sample is accepted every clock and its coefficient appears two clocks later. When the consumer holds `out_ready` low, the output word is frozen. The two internal stages then fill up, and `in_ready` falls only when both stages hold data and the output is stalled. An input is accepted on a rising edge where `in_valid` and `in_ready` are both high. An output is delivered on a rising edge where `out_valid` and `out_ready` are both high.

The table contents are generated at elaboration by a formula, so nothing is loaded at run time.

Top module: `octave_table_lookup`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: An input v with 0 <= v <= 511 selects table address v.
- R3: An input v with its highest set bit at position k (9 <= k <= 14) selects address 512 + (k-9)*256 + v[k-1:k-8]. Each octave above 511 therefore has 256 addresses, and its decimation ratio doubles from one octave to the next.
- R4: The table word at address a is (a*40503 + 12345) mod 2^26, and it is driven on `out_data`.
- R5: With `out_ready` held high, a sample accepted at one rising edge is presented with `out_valid` high after the second rising edge. A sample can be accepted on every clock.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change on the next cycle.
- R7: `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1. Samples are delivered in acceptance order, with none lost or duplicated.
- R8: At segment edges, 511->511, 512->512, 513->512, 1023->767, 1024->768, 16383->1791, 16384->1792 and 32767->2047.
- R9: No more than two accepted samples are ever held undelivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample |
| in_value | input | 15 | Unsigned input sample |
| out_valid | output | 1 | Coefficient present |
| out_ready | input | 1 | Consumer takes the coefficient |
| out_data | output | 26 | Coefficient word |

## Verification
The bound checker watches the stream protocol on every cycle. It checks that the output holds during a stall, that `in_ready` is high when a slot is free, that the two-cycle path holds, that an idle output follows reset, and that no more than two samples are in flight. Whether the address is right for each input value can only be shown by the bench's scenarios. The bench compares every delivered word against a behavioural octave search and the table formula. It also shows that the stall limit is exactly two samples, and it covers the segment edges listed in R8.

// File: rtl/octave_tbl_pkg.sv
package octave_tbl_pkg;
  localparam int unsigned DEF_IN_W    = 15;
  localparam int unsigned DEF_LIN_LOG = 9;
  localparam int unsigned DEF_SEG_BIT = 8;
  localparam int unsigned DEF_DATA_W  = 26;

  // Table word generator; callers truncate to their data width.
  function automatic longint unsigned coef_value(input int unsigned a);
    return longint'(a) * 64'd40503 + 64'd12345;
  endfunction
endpackage

// File: rtl/octave_seg_locate.sv
module octave_seg_locate #(
  parameter int unsigned IN_W    = 15,
  parameter int unsigned LIN_LOG = 9,
  parameter int unsigned SEG_W   = 3
) (
  input  logic [IN_W-1:0]  val,
  output logic [SEG_W-1:0] seg
);
  // seg 0 = linear region, seg j = leading one at bit LIN_LOG+j-1
  always_comb begin
    seg = '0;
    for (int b = LIN_LOG; b < IN_W; b++) begin
      if (val[b]) seg = SEG_W'(b - LIN_LOG + 1);
    end
  end
endmodule

// File: rtl/octave_addr_build.sv
module octave_addr_build #(
  parameter int unsigned IN_W    = 15,
  parameter int unsigned LIN_LOG = 9,
  parameter int unsigned SEG_BIT = 8,
  parameter int unsigned SEG_W   = 3,
  parameter int unsigned ADDR_W  = 11
) (
  input  logic [IN_W-2:0]   val,
  input  logic [SEG_W-1:0]  seg,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned NSEG = IN_W - LIN_LOG + 1;

  logic [ADDR_W-1:0] cand [NSEG];

  assign cand[0] = ADDR_W'(val[LIN_LOG-1:0]);

  for (genvar j = 1; j < NSEG; j++) begin : g_oct
    localparam int unsigned TOP  = LIN_LOG + j - 1;
    localparam int unsigned BASE = (1 << LIN_LOG) + (j - 1) * (1 << SEG_BIT);
    assign cand[j] = ADDR_W'(BASE) + ADDR_W'(val[TOP-1 -: SEG_BIT]);
  end

  always_comb begin
    addr = cand[0];
    for (int j = 1; j < NSEG; j++) begin
      if (int'(seg) == j) addr = cand[j];
    end
  end
endmodule

// File: rtl/octave_coef_rom.sv
module octave_coef_rom #(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 26
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(octave_tbl_pkg::coef_value(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/octave_table_lookup.sv
module octave_table_lookup #(
  parameter int unsigned IN_W    = octave_tbl_pkg::DEF_IN_W,
  parameter int unsigned LIN_LOG = octave_tbl_pkg::DEF_LIN_LOG,
  parameter int unsigned SEG_BIT = octave_tbl_pkg::DEF_SEG_BIT,
  parameter int unsigned DATA_W  = octave_tbl_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_value,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned NSEG   = IN_W - LIN_LOG + 1;
  localparam int unsigned SEG_W  = $clog2(NSEG);
  localparam int unsigned DEPTH  = (1 << LIN_LOG) + (NSEG - 1) * (1 << SEG_BIT);
  localparam int unsigned ADDR_W = $clog2(DEPTH);

  logic [SEG_W-1:0]  seg_c;
  logic [ADDR_W-1:0] addr_c, addr_q;
  logic              s1_vld, s2_vld, s1_en, s2_en;

  octave_seg_locate #(.IN_W(IN_W), .LIN_LOG(LIN_LOG), .SEG_W(SEG_W)) u_loc (
    .val(in_value), .seg(seg_c)
  );

  octave_addr_build #(.IN_W(IN_W), .LIN_LOG(LIN_LOG), .SEG_BIT(SEG_BIT),
                      .SEG_W(SEG_W), .ADDR_W(ADDR_W)) u_addr (
    .val(in_value[IN_W-2:0]), .seg(seg_c), .addr(addr_c)
  );

  // stage enables: a stage loads when empty or when its content moves on
  assign s2_en    = !s2_vld || out_ready;
  assign s1_en    = !s1_vld || s2_en;
  assign in_ready = s1_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      addr_q <= '0;
    end else if (s1_en) begin
      s1_vld <= in_valid;
      if (in_valid) addr_q <= addr_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     s2_vld <= 1'b0;
    else if (s2_en) s2_vld <= s1_vld;
  end

  octave_coef_rom #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .clk(clk), .rd_en(s2_en && s1_vld), .rd_addr(addr_q), .rd_data(out_data)
  );

  assign out_valid = s2_vld;
endmodule

// File: rtl/octave_table_lookup_chk.sv
module octave_table_lookup_chk #(
  parameter int unsigned DATA_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  logic [2:0] occ;
  logic       acc, del;

  assign acc = in_valid && in_ready;
  assign del = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + {2'b0, acc} - {2'b0, del};
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!out_valid && in_ready)); // R1
  AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc ##1 out_ready |=> out_valid); // R5
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
  AST_READY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready); // R7
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 3'd0) |-> !out_valid); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 3'd2); // R9
endmodule

bind octave_table_lookup octave_table_lookup_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/octave_table_lookup_tb_top.sv
`timescale 1ns/100ps
module octave_table_lookup_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [14:0] in_value = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [25:0] out_data;

  always #2.5 clk = ~clk;

  octave_table_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int checks = 0, errors = 0;
  int acc_total = 0, pop_total = 0, cycle = 0;
  bit done = 0;
  int unsigned exp_q[$];
  int          val_q[$];

  function automatic int ref_addr(int v);
    int k;
    if (v < 512) return v;
    k = 9;
    while ((v >> (k + 1)) != 0) k++;
    return 512 + (k - 9) * 256 + ((v >> (k - 8)) & 255);
  endfunction

  function automatic int unsigned ref_word(int a);
    longint w;
    w = longint'(a) * 40503 + 12345;
    return int'(w & 64'h3FF_FFFF);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  // Monitor: samples 0.5 ns before each rising edge
  bit          prev_stall = 0;
  logic [25:0] prev_data = '0;
  always begin
    @(negedge clk);
    #2;
    cycle++;
    if (rst_n) begin
      if (prev_stall) begin
        check(out_valid === 1'b1, "R6 valid held", out_valid, 1);
        check(out_data === prev_data, "R6 data held", out_data, prev_data);
      end
      check(!(!out_valid || out_ready) || in_ready, "R7 in_ready", in_ready, 1);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R7 extra output", out_data, 0);
        else begin
          int unsigned e;
          int v;
          e = exp_q.pop_front();
          v = val_q.pop_front();
          check(out_data === 26'(e), v < 512 ? "R2/R4 word" : "R3/R4 word", out_data, e);
          pop_total++;
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_word(ref_addr(int'(in_value))));
        val_q.push_back(int'(in_value));
        acc_total++;
      end
      check(acc_total - pop_total <= 2, "R9 in flight", acc_total - pop_total, 2);
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  task automatic send(int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_value = 15'(v);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  initial begin
    int edges[15] = '{0, 1, 511, 512, 513, 1023, 1024, 2047, 2048, 4095,
                      8191, 16383, 16384, 32766, 32767};
    int err0, pop0, acc0;
    repeat (3) @(negedge clk);
    #2;
    check(out_valid === 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready === 1'b1, "R1 in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(out_valid === 1'b0, "R1 out_valid after reset", out_valid, 0);

    // R5: single sample latency
    send(700);
    @(negedge clk);
    in_valid = 1'b0;
    #2.2;
    check(out_valid === 1'b0, "R5 one edge", out_valid, 0);
    @(negedge clk);
    #2.2;
    check(out_valid === 1'b1, "R5 two edges", out_valid, 1);
    idle(3);

    // R8: segment edges back to back, with the R5 full-rate count
    err0 = errors;
    pop0 = pop_total;
    foreach (edges[i]) send(edges[i]);
    idle(3);
    check(pop_total - pop0 == 15, "R5 full rate", pop_total - pop0, 15);
    check(errors == err0, "R8 edge words", errors - err0, 0);
    check(ref_addr(16384) == 1792 && ref_addr(513) == 512, "R8 model",
          ref_addr(16384), 1792);

    // R7: stalled output, only two samples taken
    acc0 = acc_total;
    @(negedge clk);
    out_ready = 1'b0;
    for (int i = 0; i < 6; i++) send(1000 + i * 3000);
    idle(1);
    #2;
    check(acc_total - acc0 == 2, "R7 stall limit", acc_total - acc0, 2);
    check(in_ready === 1'b0, "R7 in_ready low when full", in_ready, 0);
    @(negedge clk);
    out_ready = 1'b1;
    idle(4);

    // random traffic with back-pressure
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 3) != 0);
      if (!in_valid || in_ready) begin
        in_valid = ($urandom_range(0, 4) != 0);
        in_value = 15'($urandom_range(0, 32767) >> $urandom_range(0, 14));
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    idle(5);
    check(exp_q.size() == 0, "R7 drained", exp_q.size(), 0);
    check(acc_total == pop_total, "R7 count match", pop_total, acc_total);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R5 actual=timeout expected=finish");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule